// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver Slice

This block is one slice of a bidirectional bus transceiver. It moves a data word from a push-pull A side to an open-drain, wired-OR B side, and from B back to A. Each direction has its own four controls: an active-low output enable, a latch enable, an active-low capture enable and a capture clock. These controls choose, per direction, between three ways of moving data. In transparent mode the input goes straight through. In latched mode a level-held copy is kept. In registered mode a copy is taken on a clock edge. A wide part is built by placing several slices side by side.

The block runs on a system clock. Each direction clock and latch enable is sampled by the system clock. Their edges are detected against the value seen one system clock earlier. Transparency is combinational, so a direction's output follows its input while that direction's latch enable is high. The stored word is written only at system clock edges. The A side appears as a data output plus a per-bit drive enable. The B side appears only as a per-bit pull-low request, because an open-drain B line can never be driven high.

Top module: `busXcvrSlice`

## Requirements
- R1: When abLe is 1 and abOeN is 0, bPullLow equals the bitwise inverse of aIn in the same cycle, whatever the value of abCeN.
- R2: When abCeN is 0 and abLe is 0, a system clock edge at which abClk reads 1 after reading 0 at the previous edge stores aIn. From that edge on, bPullLow shows the inverse of the stored word while abLe stays 0.
- R3: While abCeN is 0 and abLe is 1, the store takes aIn at every system clock edge. After abLe falls, the last word taken is held, whatever aIn does and whether abClk sits high or low, until abClk rises.
- R4: While abCeN is 1, neither the latch path nor the clock path writes the store, so the held word is kept. Transparency with abLe at 1 still applies.
- R5: When abOeN is 1, bPullLow is all zeros, which releases every B line.
- R6: A B line is pulled low only when abOeN is 0 and the selected A-to-B data bit is 0. No port drives a B line high.
- R7: The B-to-A direction follows R1 to R4 with bIn, baLe, baCeN and baClk. aOut carries the selected word. aOe is all ones when baOeN is 0 and all zeros when baOeN is 1.
- R8: The controls of one direction never change the stored word or the outputs of the other direction.
- R9: While rstN is 0, both stored words are zero, and both sampled clocks are taken as having been 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the direction clocks and latch enables |
| rstN | input | 1 | Asynchronous active-low reset |
| abOeN | input | 1 | A-to-B output enable, active low |
| abLe | input | 1 | A-to-B latch enable, transparent when 1 |
| abCeN | input | 1 | A-to-B capture enable, active low |
| abClk | input | 1 | A-to-B capture clock, rising edge |
| baOeN | input | 1 | B-to-A output enable, active low |
| baLe | input | 1 | B-to-A latch enable, transparent when 1 |
| baCeN | input | 1 | B-to-A capture enable, active low |
| baClk | input | 1 | B-to-A capture clock, rising edge |
| aIn | input | SLICE_W | Data read from the A pins |
| aOut | output | SLICE_W | Data to drive on the A pins |
| aOe | output | SLICE_W | Per-bit drive enable for the A pins |
| bIn | input | SLICE_W | Data read from the B pins |
| bPullLow | output | SLICE_W | Per-bit pull-low request for the open-drain B pins |

## Verification
The stimulus is mostly random, with a fixed seed. Each direction's latch enable is high about a quarter of the time, its capture enable is inhibited about a quarter of the time, and its clock toggles freely. This mix separates the transparent, latched, registered and inhibited cases, and keeps the two directions independent of each other.

Several directed sequences cover the cases that random stimulus rarely reaches:
- a latch enable that falls while the direction clock is high, then a clock that drops without rising, which tells a held latch apart from a false edge capture;
- a clock rise during inhibit, which shows that the capture enable gates the edge path;
- an output disable, which releases every B line and blanks the A drive enables;
- reset, which clears both stores.

Each output is compared twice per cycle: once just after the inputs change, which checks the combinational transparent path, and once just after the system clock edge, which checks the capture.

// File: rtl/xcvrPkg.sv
package xcvrPkg;

  // strobes handed from a direction's control to its datapath
  typedef struct packed {
    logic pass;   // route the input straight to the output
    logic load;   // write the input into the store at this edge
  } xcvrStrobe_t;

endpackage

// File: rtl/xcvrCtrl.sv
module xcvrCtrl
  import xcvrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        le,
  input  logic        ceN,
  input  logic        dirClk,
  output xcvrStrobe_t stb
);

  logic prevClk;
  logic clkRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevClk <= 1'b0;
    else       prevClk <= dirClk;
  end

  assign clkRise  = dirClk & ~prevClk;
  assign stb.pass = le;
  // while the latch is open the store tracks the input; once closed, only a
  // direction clock rise writes it; an inhibited capture enable blocks both
  assign stb.load = ~ceN & (le | clkRise);

  // R2: with the latch closed and capture enabled, a sampled clock rise must load
  AST_EDGE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !le && dirClk && !$past(dirClk)) |-> stb.load) else $error("edge load"); // R2

endmodule

// File: rtl/xcvrPath.sv
module xcvrPath
  import xcvrPkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  xcvrStrobe_t      stb,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] store;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         store <= '0;
    else if (stb.load) store <= din;
  end

  assign dout = stb.pass ? din : store;

  AST_STORE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> store == $past(store)) else $error("store moved"); // R4
  AST_STORE_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> store == $past(din)) else $error("store missed"); // R3

endmodule

// File: rtl/busXcvrSlice.sv
module busXcvrSlice
  import xcvrPkg::*;
#(
  parameter int SLICE_W = 18
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               abOeN,
  input  logic               abLe,
  input  logic               abCeN,
  input  logic               abClk,
  input  logic               baOeN,
  input  logic               baLe,
  input  logic               baCeN,
  input  logic               baClk,
  input  logic [SLICE_W-1:0] aIn,
  output logic [SLICE_W-1:0] aOut,
  output logic [SLICE_W-1:0] aOe,
  input  logic [SLICE_W-1:0] bIn,
  output logic [SLICE_W-1:0] bPullLow
);

  localparam int NDIR = 2;   // index 0: A to B, index 1: B to A

  logic [NDIR-1:0][SLICE_W-1:0] srcData;
  logic [NDIR-1:0][SLICE_W-1:0] dirOut;
  logic [NDIR-1:0]              dirLe;
  logic [NDIR-1:0]              dirCeN;
  logic [NDIR-1:0]              dirClk;

  assign srcData = {bIn, aIn};
  assign dirLe   = {baLe, abLe};
  assign dirCeN  = {baCeN, abCeN};
  assign dirClk  = {baClk, abClk};

  for (genvar d = 0; d < NDIR; d++) begin : gDir
    xcvrStrobe_t stb;

    xcvrCtrl i_ctrl (
      .clk    (clk),
      .rstN   (rstN),
      .le     (dirLe[d]),
      .ceN    (dirCeN[d]),
      .dirClk (dirClk[d]),
      .stb    (stb)
    );

    xcvrPath #(.WIDTH(SLICE_W)) i_path (
      .clk  (clk),
      .rstN (rstN),
      .stb  (stb),
      .din  (srcData[d]),
      .dout (dirOut[d])
    );
  end

  // open-drain B: pull low only for an enabled zero bit
  assign bPullLow = {SLICE_W{~abOeN}} & ~dirOut[0];
  assign aOut     = dirOut[1];
  assign aOe      = {SLICE_W{~baOeN}};

  AST_B_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    abOeN |-> bPullLow == '0) else $error("B not released"); // R5
  AST_A_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    baOeN |-> aOe == '0) else $error("A driving"); // R7
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (!abOeN && abLe) |-> bPullLow == ~aIn) else $error("not transparent"); // R1
  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!abOeN && !abLe && $past(!abOeN) && $past(!abLe) && $past(abCeN))
      |-> bPullLow == $past(bPullLow)) else $error("inhibit broke"); // R4
  AST_BA_PASS: assert property (@(posedge clk) disable iff (!rstN)
    baLe |-> aOut == bIn) else $error("B to A not transparent"); // R7

endmodule

// File: tb/test_busXcvrSlice.sv
module test_busXcvrSlice;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic abOeN, abLe, abCeN, abClk, baOeN, baLe, baCeN, baClk;
  logic [W-1:0] aIn, bIn, aOut, aOe, bPullLow;
  logic [W-1:0] refAB, refBA;
  logic pAbClk, pBaClk;
  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  busXcvrSlice #(.SLICE_W(W)) i_busXcvrSlice (
    .clk(clk), .rstN(rstN),
    .abOeN(abOeN), .abLe(abLe), .abCeN(abCeN), .abClk(abClk),
    .baOeN(baOeN), .baLe(baLe), .baCeN(baCeN), .baClk(baClk),
    .aIn(aIn), .aOut(aOut), .aOe(aOe), .bIn(bIn), .bPullLow(bPullLow)
  );

  // reference stores built from R2, R3, R4 and R9
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refAB <= '0; refBA <= '0; pAbClk <= 1'b0; pBaClk <= 1'b0;
    end else begin
      if (!abCeN && (abLe || (abClk && !pAbClk))) refAB <= aIn;
      if (!baCeN && (baLe || (baClk && !pBaClk))) refBA <= bIn;
      pAbClk <= abClk;
      pBaClk <= baClk;
    end
  end

  function automatic logic [W-1:0] expB();
    return abOeN ? '0 : ~(abLe ? aIn : refAB);
  endfunction
  function automatic logic [W-1:0] expA();
    return baLe ? bIn : refBA;
  endfunction

  task automatic check(string tag);
    nChecks++;
    if (bPullLow !== expB()) begin
      nFails++;
      $display("FAIL %s bPullLow actual %h expected %h", tag, bPullLow, expB());
    end
    nChecks++;
    if (aOe !== {W{~baOeN}}) begin
      nFails++;
      $display("FAIL %s aOe actual %h expected %h", tag, aOe, {W{~baOeN}});
    end
    if (!baOeN) begin
      nChecks++;
      if (aOut !== expA()) begin
        nFails++;
        $display("FAIL %s aOut actual %h expected %h", tag, aOut, expA());
      end
    end
  endtask

  // inputs are set just after a falling edge; check, pass a rising edge, check
  task automatic cyc(string tag);
    #1 check(tag);
    @(posedge clk); #1 check(tag);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    {abOeN, abLe, abCeN, abClk, baOeN, baLe, baCeN, baClk} = 8'b0;
    aIn = 18'h2A5A5; bIn = 18'h15A5A;
    repeat (3) @(negedge clk);
    cyc("R9");                          // still in reset: both stores zero
    rstN = 1'b1;
    cyc("R9");

    // R1: transparent with inhibited capture
    abLe = 1; abCeN = 1; aIn = 18'h0F0F0; cyc("R1");
    // R3: latch tracks, then closes while abClk is high
    abCeN = 0; abClk = 1; aIn = 18'h12345; cyc("R3");
    abLe = 0; aIn = 18'h3FFFF; cyc("R3");
    aIn = 18'h00001; cyc("R3");
    abClk = 0; cyc("R3");               // falling clock: still held
    // R2: a clock rise captures
    aIn = 18'h2BEEF; abClk = 1; cyc("R2");
    aIn = 18'h11111; cyc("R2");
    // R4: a clock rise during inhibit is ignored
    abClk = 0; cyc("R4");
    abCeN = 1; aIn = 18'h00000; abClk = 1; cyc("R4");
    abClk = 0; cyc("R4");
    // R5 and R6: release, then only zero bits pulled
    abOeN = 1; cyc("R5");
    abOeN = 0; abLe = 1; aIn = 18'h3FFFF; cyc("R6");
    aIn = 18'h00000; cyc("R6");
    // R7: B to A capture and disable
    baCeN = 0; bIn = 18'h0ABCD; baClk = 1; cyc("R7");
    bIn = 18'h00042; baClk = 0; cyc("R7");
    baOeN = 1; cyc("R7");
    baOeN = 0;
    // R8: heavy A-to-B activity leaves B-to-A alone
    abLe = 0; abCeN = 0;
    for (int i = 0; i < 6; i++) begin
      abClk = ~abClk; aIn = W'($urandom); cyc("R8");
    end

    for (int i = 0; i < 3000; i++) begin
      abOeN = ($urandom % 8) == 0; abLe = ($urandom % 4) == 0;
      abCeN = ($urandom % 4) == 0; abClk = $urandom % 2;
      baOeN = ($urandom % 8) == 0; baLe = ($urandom % 4) == 0;
      baCeN = ($urandom % 4) == 0; baClk = $urandom % 2;
      aIn = W'($urandom); bIn = W'($urandom);
      cyc("R8");
    end

    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule